// File: doc/BRIEF.md
# Preemptive Fixed-Priority Channel Arbiter

This block picks which of sixteen data-movement channels is serviced next. Each channel raises a request line. Each channel also holds a small configuration word, written and read through a plain register port. The word carries a 4-bit priority, a "may be suspended" bit and a "never suspends others" bit. With the mode input low, the block grants the requesting channel with the largest priority value. With the mode input high, it rotates the grant among requesters instead. The granted channel stays active until its completion strobe arrives.

In fixed-priority mode, a busy channel can be interrupted. Two things must hold: the busy channel permits suspension, and a higher-priority requester is itself allowed to suspend others. When that happens, the interrupted channel is parked in a single holding slot and the preempt output pulses. When the interrupting channel completes, the parked channel is resumed. The exception is when an even higher request is waiting; that request is served first and the parked channel stays parked. The block also checks the programmed priorities continuously and raises an error whenever two channels share a value. While that error is raised, no new grant is made.

The controller has three states:
- IDLE: nothing is granted.
- BUSY: one channel is active and nothing is parked.
- PREEMPTED: a preempting channel is active and one channel is parked.

The transitions are:
- IDLE→BUSY (grant)
- BUSY→IDLE (completion)
- BUSY→PREEMPTED (preemption)
- PREEMPTED→BUSY (resume of the parked channel)
- PREEMPTED→PREEMPTED (completion with a higher waiter granted instead)

Top module: `chan_prio_arbiter`

## Requirements
- R1: After reset, channel i reads back priority i with both control bits 0; `grant_valid`, `preempt` and `cfg_err` are 0.
- R2: A write with `cfg_we`=1 updates the channel selected by `cfg_addr`. The register word has priority in bits [3:0], the "may be suspended" bit in bit 4 and the "never suspends" bit in bit 5. `cfg_rdata` shows the word of the channel selected by `cfg_addr`, updated right after the write edge.
- R3: With `rr_mode`=0, no error and nothing granted, the requester with the largest priority value (0 lowest, 15 highest) is granted. The grant appears one clock after the request is sampled.
- R4: With `rr_mode`=1, a new grant goes to the first requesting index above the last granted index, wrapping from 15 to 0.
- R5: `cfg_err` is 1 exactly when at least two channels hold the same priority value. It follows the stored configuration in the same cycle.
- R6: While `cfg_err` is 1, no new grant is issued and no preemption happens.
- R7: In BUSY with `rr_mode`=0 and no error, if the active channel's "may be suspended" bit is 1 and some other requester has a higher priority and its "never suspends" bit 0, then on the next clock the highest such requester becomes `grant_idx` and `preempt` is 1.
- R8: No preemption occurs when the active channel's "may be suspended" bit is 0, when the higher requester's "never suspends" bit is 1, or when `rr_mode`=1.
- R9: In PREEMPTED, no further preemption occurs. On `done`, the parked channel is re-granted, unless another requester (not the completing one) has a priority above the parked channel's. In that case the highest such requester is granted and the parked channel remains held.
- R10: `done` in BUSY drops `grant_valid` on the next clock; `done` in IDLE is ignored.
- R11: `preempt` is high for exactly one clock per preemption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating |
| req | input | 16 | Per-channel service request present |
| done | input | 1 | Active channel finished its service |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Channel selected for write and read |
| cfg_wdata | input | 6 | Configuration word to write |
| cfg_rdata | output | 6 | Configuration word of the selected channel |
| grant_valid | output | 1 | A channel is currently granted |
| grant_idx | output | 4 | Index of the granted channel (holds last value when idle) |
| preempt | output | 1 | One-clock pulse when the active channel is suspended |
| cfg_err | output | 1 | Duplicate priority values present |

## Verification
The bound assertions watch every cycle for several properties:
- the one-cycle preempt pulse and the index change that must accompany it;
- the absence of preemption in rotating mode, under an error, or while a channel is parked;
- the grant dropping after completion in BUSY;
- a fresh grant always naming a channel that was requesting.

Some behaviours need the bench's scenarios, because only a reference model with the full register contents can predict them:
- which channel wins among several requesters;
- the rotation order with wrap-around;
- the exact duplicate detection;
- the resume-or-skip decision on completion of a preempting channel.

// File: rtl/cparb_pkg.sv
`timescale 1ns/1ps
package cparb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_PRE  = 2'd2
    } arb_st_e;

endpackage

// File: rtl/cparb_cfg.sv
`timescale 1ns/1ps
module cparb_cfg #(
    parameter int NCH = 16,
    parameter int PW  = 4,
    localparam int IW = $clog2(NCH),
    localparam int DW = PW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic [NCH*PW-1:0] prio_flat,
    output logic [NCH-1:0]    may_susp,
    output logic [NCH-1:0]    never_pre
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [PW-1:0] p_q;
        logic          m_q;
        logic          n_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_q <= PW'(i);
                m_q <= 1'b0;
                n_q <= 1'b0;
            end else if (we && addr == IW'(i)) begin
                p_q <= wdata[PW-1:0];
                m_q <= wdata[PW];
                n_q <= wdata[PW+1];
            end
        end

        assign prio_flat[i*PW +: PW] = p_q;
        assign may_susp[i]           = m_q;
        assign never_pre[i]          = n_q;
    end

    always_comb begin
        rdata         = '0;
        rdata[PW-1:0] = prio_flat[addr*PW +: PW];
        rdata[PW]     = may_susp[addr];
        rdata[PW+1]   = never_pre[addr];
    end

endmodule

// File: rtl/cparb_dupchk.sv
`timescale 1ns/1ps
module cparb_dupchk #(
    parameter int NCH = 16,
    parameter int PW  = 4
) (
    input  logic [NCH*PW-1:0] prio_flat,
    output logic              dup
);

    logic [NCH*NCH-1:0] eq;

    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = 0; j < NCH; j++) begin : g_col
            if (j > i) begin : g_pair
                assign eq[i*NCH+j] = (prio_flat[i*PW +: PW] == prio_flat[j*PW +: PW]);
            end else begin : g_none
                assign eq[i*NCH+j] = 1'b0;
            end
        end
    end

    assign dup = |eq;

endmodule

// File: rtl/cparb_fixpick.sv
`timescale 1ns/1ps
module cparb_fixpick #(
    parameter int NCH = 16,
    parameter int PW  = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0]    mask,
    input  logic [NCH*PW-1:0] prio_flat,
    output logic              found,
    output logic [IW-1:0]     sel
);

    logic [PW-1:0] best;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c] && (!found || prio_flat[c*PW +: PW] > best)) begin
                found = 1'b1;
                sel   = IW'(c);
                best  = prio_flat[c*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/cparb_rrpick.sv
`timescale 1ns/1ps
module cparb_rrpick #(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [IW-1:0]  last,
    output logic           found,
    output logic [IW-1:0]  sel
);

    logic [IW-1:0] cand;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        cand  = '0;
        for (int k = 1; k <= NCH; k++) begin
            cand = IW'((int'(last) + k) % NCH);
            if (!found && mask[cand]) begin
                found = 1'b1;
                sel   = cand;
            end
        end
    end

endmodule

// File: rtl/chan_prio_arbiter.sv
`timescale 1ns/1ps
module chan_prio_arbiter #(
    parameter int NCH = 16,
    parameter int PW  = 4,
    localparam int IW = $clog2(NCH),
    localparam int DW = PW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rr_mode,
    input  logic [NCH-1:0] req,
    input  logic           done,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           grant_valid,
    output logic [IW-1:0]  grant_idx,
    output logic           preempt,
    output logic           cfg_err
);
    import cparb_pkg::*;

    logic [NCH*PW-1:0] prio_flat;
    logic [NCH-1:0]    may_susp;
    logic [NCH-1:0]    never_pre;

    arb_st_e       st_q, st_d;
    logic [IW-1:0] act_q, act_d;
    logic [IW-1:0] susp_q, susp_d;
    logic [IW-1:0] last_q, last_d;
    logic          pre_q, pre_d;

    logic [PW-1:0]  act_prio, susp_prio;
    logic [NCH-1:0] pre_mask, res_mask;
    logic           fix_ok, rr_ok, pre_ok, res_ok, new_ok;
    logic [IW-1:0]  fix_idx, rr_idx, pre_idx, res_idx, new_idx;

    cparb_cfg #(.NCH(NCH), .PW(PW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .prio_flat (prio_flat),
        .may_susp  (may_susp),
        .never_pre (never_pre)
    );

    cparb_dupchk #(.NCH(NCH), .PW(PW)) u_dup (
        .prio_flat (prio_flat),
        .dup       (cfg_err)
    );

    assign act_prio  = prio_flat[act_q*PW +: PW];
    assign susp_prio = prio_flat[susp_q*PW +: PW];

    for (genvar c = 0; c < NCH; c++) begin : g_mask
        logic [PW-1:0] pc;
        assign pc          = prio_flat[c*PW +: PW];
        assign pre_mask[c] = req[c] && !never_pre[c] && (act_q != IW'(c)) && (pc > act_prio);
        assign res_mask[c] = req[c] && (act_q != IW'(c)) && (pc > susp_prio);
    end

    cparb_fixpick #(.NCH(NCH), .PW(PW)) u_pick_new (
        .mask (req), .prio_flat (prio_flat), .found (fix_ok), .sel (fix_idx)
    );

    cparb_fixpick #(.NCH(NCH), .PW(PW)) u_pick_pre (
        .mask (pre_mask), .prio_flat (prio_flat), .found (pre_ok), .sel (pre_idx)
    );

    cparb_fixpick #(.NCH(NCH), .PW(PW)) u_pick_res (
        .mask (res_mask), .prio_flat (prio_flat), .found (res_ok), .sel (res_idx)
    );

    cparb_rrpick #(.NCH(NCH)) u_pick_rr (
        .mask (req), .last (last_q), .found (rr_ok), .sel (rr_idx)
    );

    assign new_ok  = rr_mode ? rr_ok  : fix_ok;
    assign new_idx = rr_mode ? rr_idx : fix_idx;

    // next-state and next-data decision
    always_comb begin
        st_d   = st_q;
        act_d  = act_q;
        susp_d = susp_q;
        last_d = last_q;
        pre_d  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!cfg_err && new_ok) begin
                    st_d   = ST_BUSY;
                    act_d  = new_idx;
                    last_d = new_idx;
                end
            end
            ST_BUSY: begin
                if (done) begin
                    st_d = ST_IDLE;
                end else if (!rr_mode && !cfg_err && may_susp[act_q] && pre_ok) begin
                    st_d   = ST_PRE;
                    susp_d = act_q;
                    act_d  = pre_idx;
                    last_d = pre_idx;
                    pre_d  = 1'b1;
                end
            end
            ST_PRE: begin
                if (done) begin
                    if (!cfg_err && res_ok) begin
                        act_d  = res_idx;
                        last_d = res_idx;
                    end else begin
                        act_d = susp_q;
                        st_d  = ST_BUSY;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            act_q  <= '0;
            susp_q <= '0;
            last_q <= IW'(NCH - 1);
            pre_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            act_q  <= act_d;
            susp_q <= susp_d;
            last_q <= last_d;
            pre_q  <= pre_d;
        end
    end

    // outputs
    always_comb begin
        grant_valid = (st_q != ST_IDLE);
        grant_idx   = act_q;
        preempt     = pre_q;
    end

endmodule

// File: rtl/chan_prio_arbiter_chk.sv
`timescale 1ns/1ps
module chan_prio_arbiter_chk #(
    parameter int NCH = 16,
    localparam int IW = $clog2(NCH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rr_mode,
    input logic [NCH-1:0]     req,
    input logic               done,
    input logic               grant_valid,
    input logic [IW-1:0]      grant_idx,
    input logic               preempt,
    input logic               cfg_err,
    input cparb_pkg::arb_st_e st
);
    import cparb_pkg::*;

    assert_grant_from_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(req) & (NCH'(1) << grant_idx)) != '0));

    assert_err_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !grant_valid) |=> !grant_valid);

    assert_err_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !preempt);

    assert_preempt_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> (grant_valid && $past(grant_valid) && grant_idx != $past(grant_idx)));

    assert_rr_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rr_mode |=> !preempt);

    assert_parked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRE && !done) |=> (grant_valid && !preempt && grant_idx == $past(grant_idx)));

    assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && done) |=> (!grant_valid && !preempt));

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |=> !preempt);

endmodule

bind chan_prio_arbiter chan_prio_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rr_mode     (rr_mode),
    .req         (req),
    .done        (done),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .preempt     (preempt),
    .cfg_err     (cfg_err),
    .st          (st_q)
);

// File: tb/sim_chan_prio_arbiter.sv
`timescale 1ns/1ps
module sim_chan_prio_arbiter;
    localparam int NCH = 16;
    localparam int IW  = 4;
    localparam int DW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rr_mode = 1'b0;
    logic           done = 1'b0;
    logic           cfg_we = 1'b0;
    logic [NCH-1:0] req = '0;
    logic [IW-1:0]  cfg_addr = '0;
    logic [DW-1:0]  cfg_wdata = '0;
    logic [DW-1:0]  cfg_rdata;
    logic           grant_valid;
    logic [IW-1:0]  grant_idx;
    logic           preempt;
    logic           cfg_err;

    always #2.5 clk = ~clk;

    chan_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .req(req), .done(done),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .preempt(preempt), .cfg_err(cfg_err)
    );

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    ended = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int m_prio[NCH];
    int m_ap[NCH];
    int m_np[NCH];
    int m_st;      // 0 idle, 1 busy, 2 parked
    int m_act, m_susp, m_last, m_pre;

    function automatic bit m_dup();
        for (int i = 0; i < NCH; i++)
            for (int j = i + 1; j < NCH; j++)
                if (m_prio[i] == m_prio[j]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_best(int thr, int excl, bit use_np);
        int w = -1;
        int wp = -1;
        for (int c = 0; c < NCH; c++)
            if (req[c] && c != excl && m_prio[c] > thr && !(use_np && m_np[c] != 0) && m_prio[c] > wp) begin
                w = c;
                wp = m_prio[c];
            end
        return w;
    endfunction

    function automatic int m_rot();
        for (int k = 1; k <= NCH; k++)
            if (req[(m_last + k) % NCH]) return (m_last + k) % NCH;
        return -1;
    endfunction

    task automatic model_step();
        int  w;
        bit  e;
        if (!rst_n) begin
            m_st = 0; m_act = 0; m_susp = 0; m_last = NCH - 1; m_pre = 0;
            for (int c = 0; c < NCH; c++) begin
                m_prio[c] = c; m_ap[c] = 0; m_np[c] = 0;
            end
            return;
        end
        e = m_dup();
        m_pre = 0;
        if (m_st == 0) begin
            if (!e) begin
                w = rr_mode ? m_rot() : m_best(-1, -1, 1'b0);
                if (w >= 0) begin m_act = w; m_last = w; m_st = 1; end
            end
        end else if (m_st == 1) begin
            if (done) m_st = 0;
            else if (!rr_mode && !e && m_ap[m_act] != 0) begin
                w = m_best(m_prio[m_act], m_act, 1'b1);
                if (w >= 0) begin
                    m_susp = m_act; m_act = w; m_last = w; m_pre = 1; m_st = 2;
                end
            end
        end else begin
            if (done) begin
                w = e ? -1 : m_best(m_prio[m_susp], m_act, 1'b0);
                if (w >= 0) begin m_act = w; m_last = w; end
                else begin m_act = m_susp; m_st = 1; end
            end
        end
        if (cfg_we) begin
            m_prio[cfg_addr] = int'(cfg_wdata[3:0]);
            m_ap[cfg_addr]   = int'(cfg_wdata[4]);
            m_np[cfg_addr]   = int'(cfg_wdata[5]);
        end
    endtask

    task automatic chk(string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare();
        chk("grant_valid", int'(grant_valid), (m_st != 0) ? 1 : 0);
        if (m_st != 0) chk("grant_idx", int'(grant_idx), m_act);
        chk("preempt", int'(preempt), m_pre);
        chk("cfg_err", int'(cfg_err), m_dup() ? 1 : 0);
        chk("cfg_rdata", int'(cfg_rdata),
            m_prio[cfg_addr] | (m_ap[cfg_addr] << 4) | (m_np[cfg_addr] << 5));
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int ch, int val);
        cfg_we = 1'b1; cfg_addr = IW'(ch); cfg_wdata = DW'(val);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic fin();
        done = 1'b1; tick(); done = 1'b0; tick();
    endtask

    task automatic drain();
        req = '0;
        repeat (3) fin();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !ended) begin
            ended = 1'b1;
            bad++; total++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset values
        tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        for (int a = 0; a < NCH; a++) begin
            cfg_addr = IW'(a);
            tick();
            chk("reset prio R1", int'(cfg_rdata), a);
        end

        // R2: register layout and readback
        tag = "R2";
        wr(6, 6'h3A);
        tick();
        chk("readback R2", int'(cfg_rdata), 'h3A);
        wr(6, 6'h06);
        tick();

        // R3: fixed priority winner
        tag = "R3";
        req = 16'h0124;
        tick();
        chk("winner R3", int'(grant_idx), 8);
        tick();
        tag = "R10";
        req = 16'h0000;
        fin();
        chk("released R10", int'(grant_valid), 0);
        tag = "R10";
        done = 1'b1; tick(); done = 1'b0;
        tag = "R3";
        for (int c = 0; c < NCH; c++) wr(c, NCH - 1 - c);
        req = 16'h0124;
        tick();
        chk("inverted winner R3", int'(grant_idx), 2);
        drain();
        for (int c = 0; c < NCH; c++) wr(c, c);

        // R5 / R6: duplicate priorities
        tag = "R5";
        wr(3, 5);
        chk("dup flag R5", int'(cfg_err), 1);
        tag = "R6";
        req = 16'h0008;
        repeat (3) tick();
        chk("no grant under error R6", int'(grant_valid), 0);
        tag = "R5";
        wr(3, 3);
        chk("dup cleared R5", int'(cfg_err), 0);
        tick();
        drain();

        // R7 / R11 / R9: preemption and resume
        tag = "R7";
        wr(2, 6'h12);
        req = 16'h0004;
        repeat (2) tick();
        req = 16'h0204;
        tick();
        chk("preempt pulse R7", int'(preempt), 1);
        chk("preemptor R7", int'(grant_idx), 9);
        tag = "R11";
        tick();
        chk("pulse ends R11", int'(preempt), 0);
        tag = "R9";
        req = 16'h0004;
        fin();
        chk("resume R9", int'(grant_idx), 2);
        drain();
        req = 16'h0004;
        repeat (2) tick();
        req = 16'h0204;
        tick();
        req = 16'h1204;
        repeat (3) tick();
        chk("no nesting R9", int'(grant_idx), 9);
        req = 16'h1004;
        fin();
        chk("higher waiter R9", int'(grant_idx), 12);
        req = 16'h0004;
        fin();
        chk("resume after waiter R9", int'(grant_idx), 2);
        drain();

        // R8: blocked preemption cases
        tag = "R8";
        wr(2, 6'h02);
        req = 16'h0004; repeat (2) tick();
        req = 16'h0204; repeat (3) tick();
        chk("active not suspendable R8", int'(grant_idx), 2);
        drain();
        wr(2, 6'h12);
        wr(9, 6'h29);
        req = 16'h0004; repeat (2) tick();
        req = 16'h0204; repeat (3) tick();
        chk("requester never preempts R8", int'(grant_idx), 2);
        drain();
        wr(9, 6'h09);
        rr_mode = 1'b1;
        req = 16'h0004; repeat (2) tick();
        req = 16'h0204; repeat (3) tick();
        chk("rotating mode R8", int'(preempt), 0);
        drain();

        // R4: rotation with wrap
        tag = "R4";
        req = 16'h8011;
        repeat (2) tick();
        repeat (7) fin();
        drain();
        rr_mode = 1'b0;
        repeat (2) tick();

        ended = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule